// File: doc/BRIEF.md
# Clock Select Register Bank

This block is a small bank of control words on a simple 32-bit register bus: a byte address, write data, a write strobe and a combinational read-data return. It holds the divider ratio codes and mux select codes that a set of clock generators use. Each field in a word carries its own write-enable in its most significant bit. A write changes only the fields whose enable bit is set in the write data. The other fields keep their value, so software can retune one clock without reading the word first.

Word 1 drives its codes to the generators directly. Words 9 and 10 are staged. A write lands in a shadow copy, which reads back at once. The generators see nothing new until software writes 1 to word 11. Word 11 then reads 1 and a request line is raised towards the generators. When the generators return an acknowledge pulse, the shadow copies move into the active copies and word 11 reads 0 again. Software polls word 11 to learn that the change has been applied.

Top module: `clk_sel_bank`

## Requirements
- R1: Control word n sits at byte offset (n-1)*4. Word 1 is at 0x00, word 9 at 0x20, word 10 at 0x24 and word 11 at 0x28. Reads and writes at these offsets reach only that word.
- R2: A field takes the low bits of its slice of the write data only when the slice's top bit is 1. That top bit is the field's enable and always reads back as 0. Fields (lsb, width) are: word 1: (0,3) (3,5) (8,5) (13,5) (18,4) (22,6) (28,3); word 9: (0,7) (7,5) (12,4) (16,4) (20,4); word 10: (0,3) (3,4) (7,3). Bits outside fields read 0.
- R3: A field whose enable bit is 0 in the write data keeps its old code.
- R4: A write to word 1 shows on `imm_sel_o` after the clock edge that accepts it.
- R5: A write to word 9 or 10 reads back after the accepting edge. `grp_a_sel_o` and `grp_b_sel_o` stay unchanged until a commit.
- R6: Writing data with bit 0 set to word 11 while no request is pending raises `commit_req_o` after that edge, and word 11 then reads 1. A write with bit 0 clear has no effect.
- R7: A cycle with `commit_ack_i` high while a request is pending copies the word 9 and 10 shadows to the group outputs and clears the request. Word 11 then reads 0.
- R8: `commit_ack_i` with no request pending has no effect. A write to word 11 while a request is pending, including one in the same cycle as the acknowledge, is ignored.
- R9: If a staged word is written in the same cycle that a commit is acknowledged, the group output takes the shadow value from before that write. The shadow keeps the new value, which waits for the next commit.
- R10: After reset, word 1 reads 0x00000001, word 9 reads 0x0033331F, word 10 reads 0x00000099 and word 11 reads 0. The outputs equal these codes and `commit_req_o` is low.
- R11: Every other byte offset, including unaligned ones, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| imm_sel_o | output | 32 | Word 1 codes, enable positions zero |
| grp_a_sel_o | output | 32 | Active word 9 codes |
| grp_b_sel_o | output | 32 | Active word 10 codes |
| commit_req_o | output | 1 | Change request pending |
| commit_ack_i | input | 1 | Generators applied the staged codes |

## Verification
Two events can fall in the same cycle: a bus write to a staged word, or to the request word, and the acknowledge that commits the staged words. The bench provokes this by driving the write strobe and `commit_ack_i` in the same cycle while a request is pending. It then checks that the group output shows the older shadow value and that the readback shows the newer one. It also checks that the request word reads 0 afterwards, because the simultaneous re-request was dropped.

// File: rtl/clk_sel_bank_pkg.sv
package clk_sel_bank_pkg;

   localparam int unsigned WORD_W = 32;

   // control word numbers; the offset of word n is (n-1)*4
   localparam int unsigned IMM_WORD  = 1;
   localparam int unsigned GRPA_WORD = 9;
   localparam int unsigned GRPB_WORD = 10;
   localparam int unsigned REQ_WORD  = 11;

   function automatic int unsigned word_ofs(int unsigned n);
      return (n - 1) * 4;
   endfunction

   // lowest enable bit at or above bit b, -1 if none
   function automatic int en_pos(logic [WORD_W-1:0] en, int b);
      int p = -1;
      for (int i = int'(WORD_W) - 1; i >= b; i--)
         if (en[i]) p = i;
      return p;
   endfunction

   // enables and codes disjoint, every code bit has an enable above it
   function automatic bit layout_ok(logic [WORD_W-1:0] en, logic [WORD_W-1:0] code);
      bit ok = ((en & code) == '0);
      for (int b = 0; b < int'(WORD_W); b++)
         if (code[b] && en_pos(en, b) < 0) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/csr_commit_ctl.sv
module csr_commit_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr_i,
   input  logic ack_i,
   output logic pending_o,
   output logic commit_o
);

   logic pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending_q <= 1'b0;
      else if (pending_q && ack_i)
         pending_q <= 1'b0;
      else if (!pending_q && req_wr_i)
         pending_q <= 1'b1;
   end

   assign pending_o = pending_q;
   assign commit_o  = pending_q & ack_i;

   AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_q && req_wr_i) |=> pending_q);          // R6
   AST_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && !ack_i) |=> pending_q);             // R6
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q && ack_i) |=> !pending_q);             // R7
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending_q && !req_wr_i) |=> !pending_q);        // R8

endmodule

// File: rtl/csr_field_word.sv
module csr_field_word
   import clk_sel_bank_pkg::*;
#(
   parameter logic [WORD_W-1:0] EN_MASK   = '0,
   parameter logic [WORD_W-1:0] CODE_MASK = '0,
   parameter logic [WORD_W-1:0] RST_VAL   = '0,
   parameter bit                STAGED    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              commit_i,
   output logic [WORD_W-1:0] shadow_o,
   output logic [WORD_W-1:0] active_o
);

   if (!layout_ok(EN_MASK, CODE_MASK)) begin : g_bad_layout
      $error("csr_field_word: field layout invalid");
   end
   if ((RST_VAL & ~CODE_MASK) != '0) begin : g_bad_reset
      $error("csr_field_word: reset value outside code bits");
   end

   logic [WORD_W-1:0] bit_wen;
   logic [WORD_W-1:0] shadow_q;

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int EP = en_pos(EN_MASK, b);
      if (CODE_MASK[b] && EP >= 0) begin : g_code
         assign bit_wen[b] = wr_i & wdata_i[EP];
      end else begin : g_fixed
         assign bit_wen[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow_q <= RST_VAL;
      else
         shadow_q <= (shadow_q & ~bit_wen) | (wdata_i & bit_wen);
   end

   assign shadow_o = shadow_q;

   AST_KEEP_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(shadow_q));                     // R3

   if (STAGED) begin : g_staged
      logic [WORD_W-1:0] active_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            active_q <= RST_VAL;
         else if (commit_i)
            active_q <= shadow_q;
      end

      assign active_o = active_q;

      AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !commit_i |=> $stable(active_q));              // R5
      AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
         commit_i |=> (active_q == $past(shadow_q)));   // R9
   end else begin : g_direct
      logic unused_commit;
      assign unused_commit = commit_i;
      assign active_o      = shadow_q;
   end

endmodule

// File: rtl/clk_sel_bank.sv
module clk_sel_bank
   import clk_sel_bank_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter logic [WORD_W-1:0] IMM_EN     = 32'h4822_1084,
   parameter logic [WORD_W-1:0] IMM_CODE   = 32'h37DD_EF7B,
   parameter logic [WORD_W-1:0] IMM_RST    = 32'h0000_0001,
   parameter logic [WORD_W-1:0] GRPA_EN    = 32'h0088_8840,
   parameter logic [WORD_W-1:0] GRPA_CODE  = 32'h0077_77BF,
   parameter logic [WORD_W-1:0] GRPA_RST   = 32'h0033_331F,
   parameter logic [WORD_W-1:0] GRPB_EN    = 32'h0000_0244,
   parameter logic [WORD_W-1:0] GRPB_CODE  = 32'h0000_01BB,
   parameter logic [WORD_W-1:0] GRPB_RST   = 32'h0000_0099
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   output logic [31:0]       imm_sel_o,
   output logic [31:0]       grp_a_sel_o,
   output logic [31:0]       grp_b_sel_o,
   output logic              commit_req_o,
   input  logic              commit_ack_i
);

   localparam logic [ADDR_W-1:0] A_IMM  = ADDR_W'(word_ofs(IMM_WORD));
   localparam logic [ADDR_W-1:0] A_GRPA = ADDR_W'(word_ofs(GRPA_WORD));
   localparam logic [ADDR_W-1:0] A_GRPB = ADDR_W'(word_ofs(GRPB_WORD));
   localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'(word_ofs(REQ_WORD));

   if ((word_ofs(REQ_WORD) + 4) > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("clk_sel_bank: ADDR_W too small for the word map");
   end

   logic hit_imm, hit_grpa, hit_grpb, hit_req, hit_any;
   logic pending, commit;
   logic [WORD_W-1:0] imm_shadow, grpa_shadow, grpb_shadow;

   assign hit_imm  = (bus_addr == A_IMM);
   assign hit_grpa = (bus_addr == A_GRPA);
   assign hit_grpb = (bus_addr == A_GRPB);
   assign hit_req  = (bus_addr == A_REQ);
   assign hit_any  = hit_imm | hit_grpa | hit_grpb | hit_req;

   csr_field_word #(
      .EN_MASK(IMM_EN), .CODE_MASK(IMM_CODE), .RST_VAL(IMM_RST), .STAGED(1'b0)
   ) u_imm (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_we & hit_imm), .wdata_i(bus_wdata),
      .commit_i(1'b0), .shadow_o(imm_shadow), .active_o(imm_sel_o)
   );

   csr_field_word #(
      .EN_MASK(GRPA_EN), .CODE_MASK(GRPA_CODE), .RST_VAL(GRPA_RST), .STAGED(1'b1)
   ) u_grpa (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_we & hit_grpa), .wdata_i(bus_wdata),
      .commit_i(commit), .shadow_o(grpa_shadow), .active_o(grp_a_sel_o)
   );

   csr_field_word #(
      .EN_MASK(GRPB_EN), .CODE_MASK(GRPB_CODE), .RST_VAL(GRPB_RST), .STAGED(1'b1)
   ) u_grpb (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_we & hit_grpb), .wdata_i(bus_wdata),
      .commit_i(commit), .shadow_o(grpb_shadow), .active_o(grp_b_sel_o)
   );

   csr_commit_ctl u_commit (
      .clk(clk), .rst_n(rst_n),
      .req_wr_i(bus_we & hit_req & bus_wdata[0]),
      .ack_i(commit_ack_i), .pending_o(pending), .commit_o(commit)
   );

   assign commit_req_o = pending;

   always_comb begin
      bus_rdata = '0;
      if (hit_imm)  bus_rdata = imm_shadow;
      if (hit_grpa) bus_rdata = grpa_shadow;
      if (hit_grpb) bus_rdata = grpb_shadow;
      if (hit_req)  bus_rdata = {31'd0, pending};
   end

   AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !hit_any) |=> ($stable(imm_shadow) && $stable(grpa_shadow)
                                && $stable(grpb_shadow)));   // R11

endmodule

// File: tb/tb_clk_sel_bank.sv
`timescale 1ns/1ps
module tb_clk_sel_bank;

   localparam logic [31:0] EN1 = 32'h4822_1084, CD1 = 32'h37DD_EF7B;
   localparam logic [31:0] EN9 = 32'h0088_8840, CD9 = 32'h0077_77BF;
   localparam logic [31:0] ENA = 32'h0000_0244, CDA = 32'h0000_01BB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata, imm_sel_o, grp_a_sel_o, grp_b_sel_o;
   logic        commit_req_o;
   logic        commit_ack_i = 1'b0;

   int checks = 0, fails = 0;
   bit done = 0;

   // bench model
   logic [31:0] m1, m9, m10, a9, a10, xs;
   logic        pend;

   always #2 clk = ~clk;

   clk_sel_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .imm_sel_o(imm_sel_o),
      .grp_a_sel_o(grp_a_sel_o), .grp_b_sel_o(grp_b_sel_o),
      .commit_req_o(commit_req_o), .commit_ack_i(commit_ack_i)
   );

   function automatic logic [31:0] apply(logic [31:0] old, logic [31:0] wd,
                                         logic [31:0] en, logic [31:0] code);
      logic cur = 1'b0;
      logic [31:0] r = old;
      for (int b = 31; b >= 0; b--) begin
         if (en[b]) cur = wd[b];
         if (code[b] && cur) r[b] = wd[b];
      end
      return r;
   endfunction

   function automatic logic [31:0] nxt(logic [31:0] s);
      logic [31:0] t = s;
      t = t ^ (t << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                      input string tag, input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   // one bus cycle, model updated from pre-edge state
   task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic ack);
      logic [31:0] o9 = m9, o10 = m10;
      logic        op = pend;
      if (we && a == 8'h00) m1 = apply(m1, d, EN1, CD1);
      if (we && a == 8'h20) m9 = apply(m9, d, EN9, CD9);
      if (we && a == 8'h24) m10 = apply(m10, d, ENA, CDA);
      if (ack && op) begin
         a9 = o9; a10 = o10; pend = 1'b0;
      end else if (!op && we && a == 8'h28 && d[0]) pend = 1'b1;
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d; commit_ack_i = ack;
      @(negedge clk);
      bus_we = 1'b0; commit_ack_i = 1'b0;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] d;
      rd(8'h00, d); chk(d, m1, tag, "word1");
      rd(8'h20, d); chk(d, m9, tag, "word9");
      rd(8'h24, d); chk(d, m10, tag, "word10");
      rd(8'h28, d); chk(d, {31'd0, pend}, tag, "word11");
      chk(imm_sel_o, m1, tag, "imm_sel_o");
      chk(grp_a_sel_o, a9, tag, "grp_a_sel_o");
      chk(grp_b_sel_o, a10, tag, "grp_b_sel_o");
      chk({31'd0, commit_req_o}, {31'd0, pend}, tag, "commit_req_o");
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
   endtask

   initial begin
      #(4 * 150000);
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      m1 = 32'h1; m9 = 32'h0033_331F; m10 = 32'h99; a9 = m9; a10 = m10;
      pend = 1'b0; xs = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10");

      // R2 R3 R4 R1: word 1 pattern sweep
      for (int i = 0; i < 200; i++) begin
         xs = nxt(xs);
         cyc(1'b1, 8'h00, xs, 1'b0);
         check_all("R2_R3_R4");
      end
      // R2 R5: exhaustive over word 10 field bits
      for (int v = 0; v < 1024; v++) begin
         cyc(1'b1, 8'h24, 32'(v), 1'b0);
         rd(8'h24, d); chk(d, m10, "R2", "word10 sweep");
         chk(grp_b_sel_o, a10, "R5", "grp_b held");
      end
      // R2 R3 R5: word 9 patterns
      for (int i = 0; i < 150; i++) begin
         xs = nxt(xs);
         cyc(1'b1, 8'h20, xs, 1'b0);
         check_all("R2_R3_R5");
      end
      // R6: bit 0 clear does nothing, bit 0 set raises request
      cyc(1'b1, 8'h28, 32'hFFFF_FFFE, 1'b0); check_all("R6");
      cyc(1'b1, 8'h28, 32'h1, 1'b0);         check_all("R6");
      cyc(1'b0, 8'h00, 32'h0, 1'b0);         check_all("R6");
      // R7: acknowledge commits
      cyc(1'b0, 8'h00, 32'h0, 1'b1);         check_all("R7");
      // R8: acknowledge while idle ignored
      cyc(1'b1, 8'h20, 32'h0088_8840, 1'b0);
      cyc(1'b1, 8'h24, 32'h0000_0244, 1'b0);
      cyc(1'b0, 8'h00, 32'h0, 1'b1);         check_all("R8");
      // R9: staged write in the commit cycle
      cyc(1'b1, 8'h28, 32'h1, 1'b0);
      cyc(1'b1, 8'h20, 32'h00FF_FFFF, 1'b1); check_all("R9");
      chk(grp_a_sel_o, 32'h0, "R9", "old shadow committed");
      cyc(1'b1, 8'h28, 32'h1, 1'b0);
      cyc(1'b0, 8'h00, 32'h0, 1'b1);         check_all("R9");
      // R8: re-request in the acknowledge cycle is dropped
      cyc(1'b1, 8'h28, 32'h1, 1'b0);
      cyc(1'b1, 8'h28, 32'h1, 1'b1);         check_all("R8");
      // R8: second request while pending ignored, one ack clears it
      cyc(1'b1, 8'h28, 32'h1, 1'b0);
      cyc(1'b1, 8'h28, 32'h1, 1'b0);
      cyc(1'b0, 8'h00, 32'h0, 1'b1);         check_all("R8");
      // R11: all other offsets
      for (int a = 0; a < 256; a++) begin
         if (a != 8'h00 && a != 8'h20 && a != 8'h24 && a != 8'h28) begin
            cyc(1'b1, 8'(a), 32'hFFFF_FFFF, 1'b0);
            rd(8'(a), d); chk(d, 32'h0, "R11", "unmapped read");
         end
      end
      check_all("R11");
      summary();
      $finish;
   end

endmodule